// File: doc/BRIEF.md
# Power-Up Strap Sampler with Pin Turnaround

This block manages one bidirectional board pin that does two jobs in sequence. While the system comes out of reset, the pin is read as a configuration strap. Its level is captured exactly once and held. After that, the pin stays undriven for a fixed wait. When the wait ends, the output driver is switched on and the pin carries a copy of the primary clock.

The captured strap also sets the rate of a secondary clock. A high strap makes the secondary clock run at the primary rate. A low strap makes it run at half that rate. Both clocks are registered from the same edge of `clk`, so their rising edges coincide.

All clock outputs are held low until the enable point. The enable point is picked so that the first cycle seen outside is a full one. The wait is a parameter counted in `clk` cycles. The default of 28636 cycles matches roughly 2 ms at a 14.318 MHz reference.

Top module: `strap_turnaround`

## Requirements
- R1: While `rst` is high, `pin_oe`, `pin_out`, `prim_clk`, `sec_clk` and `strap_val` are all 0, whatever level `pin_in` has.
- R2: At the first rising edge of `clk` with `rst` low (edge 1), `pin_in` is captured, and `strap_val` shows that level from then on.
- R3: Changes on `pin_in` after edge 1 have no effect on `strap_val` or on the clock outputs until `rst` is asserted again. A new reset followed by a release captures the pin afresh.
- R4: `pin_oe` rises at edge E0, the first edge number that is at least DELAY_CYC+1 and a multiple of 4 (edges counted from edge 1 after reset release). Before E0 it is 0, and all clock outputs are low.
- R5: Once `pin_oe` is 1 it stays 1 until the next reset.
- R6: After enable, `prim_clk` is 1 after odd-numbered edges and 0 after even-numbered edges. Its first change after enable is therefore a rise, and its first high phase is full length.
- R7: With `strap_val` = 1 and the output enabled, `sec_clk` equals `prim_clk` every cycle.
- R8: With `strap_val` = 0 and the output enabled, `sec_clk` is 1 after edges e with e mod 4 equal to 1 or 2, and 0 otherwise. It changes only in cycles where `prim_clk` rises, and its first rise lands on the first rise of `prim_clk`.
- R9: While `pin_oe` is 1, `pin_out` equals `prim_clk`. While `pin_oe` is 0, `pin_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; every output is registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Level seen on the shared pad (strap during power-up) |
| pin_oe | output | 1 | Pad driver enable |
| pin_out | output | 1 | Clock value driven onto the pad |
| prim_clk | output | 1 | Primary clock output |
| sec_clk | output | 1 | Secondary clock, at the same rate or half rate depending on the strap |
| strap_val | output | 1 | Captured strap level |

## Verification
The hardest case to reach is a reset that arrives partway through the wait. It must restart the delay count, re-sample the strap, and keep the phase rule for the first enabled cycle. The bench reaches it by releasing reset and letting a few edges pass with the opposite strap level on the pin. It then re-asserts reset before E0 and releases again with the other level. After that, it checks the whole sequence from edge 1 once more.

Throughout each run, `pin_in` is driven to the inverse of the captured strap and toggled. This means any leak from the pad into the latch or the clocks would show up on the outputs.

// File: rtl/strap_turnaround_pkg.sv
package strap_turnaround_pkg;
  localparam int PHASE_W = 2;
  typedef logic [PHASE_W-1:0] phase_t;

  // phase sequence 0,1,2,3: primary high in 1 and 3, halved clock high in 1 and 2
  function automatic logic prim_level(input phase_t ph);
    return ph[0];
  endfunction

  function automatic logic half_level(input phase_t ph);
    return ph[0] ^ ph[1];
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic strap,
  output logic captured
);
  always_ff @(posedge clk) begin
    if (rst) begin
      strap    <= 1'b0;
      captured <= 1'b0;
    end else if (!captured) begin
      strap    <= pin_in;
      captured <= 1'b1;
    end
  end
endmodule

// File: rtl/turnaround_timer.sv
module turnaround_timer #(
  parameter int DELAY_CYC = 28636
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt  <= cnt + 1'b1;
      done <= (cnt == LAST);
    end
  end
endmodule

// File: rtl/clock_gate_gen.sv
module clock_gate_gen
  import strap_turnaround_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic strap,
  output logic oe,
  output logic pin_out,
  output logic prim,
  output logic sec
);
  phase_t ph, ph_n;
  logic   en_n;

  always_comb begin
    ph_n = ph + 1'b1;
    en_n = oe | (done && (ph_n == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= '0;
      oe      <= 1'b0;
      prim    <= 1'b0;
      sec     <= 1'b0;
      pin_out <= 1'b0;
    end else begin
      ph      <= ph_n;
      oe      <= en_n;
      prim    <= en_n & prim_level(ph_n);
      pin_out <= en_n & prim_level(ph_n);
      sec     <= en_n & (strap ? prim_level(ph_n) : half_level(ph_n));
    end
  end
endmodule

// File: rtl/strap_turnaround.sv
module strap_turnaround #(
  parameter int DELAY_CYC = 28636
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic pin_oe,
  output logic pin_out,
  output logic prim_clk,
  output logic sec_clk,
  output logic strap_val
);
  logic captured;
  logic timer_done;

  strap_capture u_cap (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .strap(strap_val), .captured(captured)
  );

  turnaround_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk(clk), .rst(rst), .done(timer_done)
  );

  clock_gate_gen u_gen (
    .clk(clk), .rst(rst), .done(timer_done), .strap(strap_val),
    .oe(pin_oe), .pin_out(pin_out), .prim(prim_clk), .sec(sec_clk)
  );
endmodule

// File: rtl/strap_turnaround_chk.sv
module strap_turnaround_chk (
  input logic clk,
  input logic rst,
  input logic pin_oe,
  input logic pin_out,
  input logic prim_clk,
  input logic sec_clk,
  input logic strap_val,
  input logic captured,
  input logic timer_done
);
  p_strap_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (captured && $past(captured)) |-> $stable(strap_val));

  p_oe_after_wait_r4: assert property (@(posedge clk) disable iff (rst)
    pin_oe |-> timer_done);

  p_quiet_until_enable_r4: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> (!prim_clk && !sec_clk && !pin_out));

  p_oe_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    pin_oe |=> pin_oe);

  p_same_rate_r7: assert property (@(posedge clk) disable iff (rst)
    (pin_oe && strap_val) |-> (sec_clk == prim_clk));

  p_half_on_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (!strap_val && (sec_clk != $past(sec_clk))) |-> $rose(prim_clk));

  p_pin_copy_r9: assert property (@(posedge clk) disable iff (rst)
    pin_oe |-> (pin_out == prim_clk));
endmodule

bind strap_turnaround strap_turnaround_chk u_chk (
  .clk(clk), .rst(rst), .pin_oe(pin_oe), .pin_out(pin_out),
  .prim_clk(prim_clk), .sec_clk(sec_clk), .strap_val(strap_val),
  .captured(captured), .timer_done(timer_done)
);

// File: tb/strap_turnaround_test.sv
module strap_turnaround_test;
  localparam int D = 10;
  localparam int E0 = ((D + 1 + 3) / 4) * 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_in = 1'b1;
  logic pin_oe, pin_out, prim_clk, sec_clk, strap_val;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  strap_turnaround #(.DELAY_CYC(D)) uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .prim_clk(prim_clk), .sec_clk(sec_clk), .strap_val(strap_val)
  );

  task automatic check(input string req, input int e, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s edge=%0d %s actual=%b expected=%b", req, e, what, act, exp);
    end
  endtask

  task automatic hold_reset(input logic lvl);
    @(negedge clk);
    rst = 1'b1;
    pin_in = lvl;
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset, pin level irrelevant
    check("R1", 0, "pin_oe", pin_oe, 1'b0);
    check("R1", 0, "prim_clk", prim_clk, 1'b0);
    check("R1", 0, "sec_clk", sec_clk, 1'b0);
    check("R1", 0, "pin_out", pin_out, 1'b0);
    check("R1", 0, "strap_val", strap_val, 1'b0);
    rst = 1'b0;
  endtask

  // run n edges after release, checking every output after each edge
  task automatic run_and_check(input logic s, input int n);
    for (int e = 1; e <= n; e++) begin
      logic oe_x, pr_x, se_x;
      @(negedge clk);
      oe_x = (e >= E0);
      pr_x = oe_x && (e % 2 == 1);
      se_x = s ? pr_x : (oe_x && ((e % 4 == 1) || (e % 4 == 2)));
      check("R2", e, "strap_val", strap_val, s);
      check("R4", e, "pin_oe", pin_oe, oe_x);
      check("R6", e, "prim_clk", prim_clk, pr_x);
      check(s ? "R7" : "R8", e, "sec_clk", sec_clk, se_x);
      check("R9", e, "pin_out", pin_out, pr_x);
      // R3: drive the pad opposite to the strap, with toggling
      pin_in = (e % 3 == 0) ? s : ~s;
    end
  endtask

  task automatic scen_strap_high();
    hold_reset(1'b1);
    run_and_check(1'b1, 40);
  endtask

  task automatic scen_strap_low();
    hold_reset(1'b0);
    run_and_check(1'b0, 40);
  endtask

  task automatic scen_reset_mid_wait();
    hold_reset(1'b1);
    repeat (5) @(negedge clk);
    // R3 / R5: a new reset re-samples and restarts the wait
    hold_reset(1'b0);
    run_and_check(1'b0, 30);
    hold_reset(1'b1);
    run_and_check(1'b1, 30);
  endtask

  task automatic scen_long_hold();
    hold_reset(1'b0);
    run_and_check(1'b0, 20);
    // R5: stays enabled, R3: strap unchanged over many more cycles
    for (int k = 0; k < 200; k++) begin
      pin_in = k[0];
      @(negedge clk);
      check("R5", k, "pin_oe", pin_oe, 1'b1);
      check("R3", k, "strap_val", strap_val, 1'b0);
    end
  endtask

  initial begin
    scen_strap_high();
    scen_strap_low();
    scen_reset_mid_wait();
    scen_long_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule